// File: doc/BRIEF.md
# Quarter-Rate Complex Derotation Mixer

This block moves a complex I/Q sample stream from a low IF of exactly one quarter of the sample rate down to zero IF, or up by the same amount. A rotating phasor at fs/4 only takes the values 1, -j, -1 and +j. The product with each sample therefore reduces to swapping I and Q and inverting signs, with no multiplier and no oscillator table. A two-bit phase counter steps once per accepted sample. In each phase two of the four signed taps (I, -I, Q, -Q) are routed to the in-phase and quadrature outputs, in the same way a matrix of eight analogue switches would route them.

The current phase is also driven out as a one-hot four-bit enable. An external analogue switch matrix can use it to close the matching switch pair. Negation saturates, so a full-scale negative input never wraps to itself. The direction of rotation is a parameter. Filtering, decimation and image rejection belong to the stages around the block.

Top module: `qrot_mixer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `phase_en` is 4'b0001 (phase 0), `out_valid` is 0, and `out_i` and `out_q` are 0.
- R2: With `DOWN`=1 (the default), an accepted sample (I,Q) taken in phase p produces (I,Q) for p=0, (Q,-I) for p=1, (-I,-Q) for p=2 and (-Q,I) for p=3.
- R3: With `DOWN`=0, the same sample produces (I,Q) for p=0, (-Q,I) for p=1, (-I,-Q) for p=2 and (Q,-I) for p=3.
- R4: Negation saturates. The most negative value -2^(W-1) becomes 2^(W-1)-1, and -(2^(W-1)-1) is produced exactly.
- R5: The phase advances 0,1,2,3,0 by one step per cycle with `in_valid` high. It holds in every cycle with `in_valid` low.
- R6: `phase_en` has exactly one bit set in every cycle, and bit k set means the next accepted sample uses phase k.
- R7: `out_i`, `out_q` and `out_valid` are registered with one cycle of latency, and `out_valid` equals `in_valid` of the previous cycle.
- R8: In a cycle after one with `in_valid` low, `out_i` and `out_q` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | W | Signed in-phase input |
| in_q | input | W | Signed quadrature input |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | W | Signed derotated in-phase output |
| out_q | output | W | Signed derotated quadrature output |
| phase_en | output | 4 | One-hot current phase enable |

## Verification
The bench drives a constant complex input, which shows the fs/4 rotation as a four-sample cycle of swaps and sign flips, and a ramp, in which every phase sees a different value and so exposes a swapped or mis-signed tap. Both directions are run side by side on shared stimulus, so a swapped direction table is visible. Irregular valid gaps separate an advance on every clock from an advance on every valid sample, and also test the hold of the outputs. Full-scale positive and negative inputs over all four phases separate saturating negation from wrapping negation.

// File: rtl/qrot_mixer.sv
module qrot_mixer #(
  parameter int W    = 12,
  parameter bit DOWN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_i,
  input  logic signed [W-1:0] in_q,
  output logic                out_valid,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q,
  output logic [3:0]          phase_en
);
  localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] sneg(input logic signed [W-1:0] x);
    return (x == SMIN) ? SMAX : -x;
  endfunction

  // tap index: 0 = +I, 1 = -I, 2 = +Q, 3 = -Q
  function automatic logic [1:0] isel(input logic [1:0] p);
    case (p)
      2'd0:    return 2'd0;
      2'd1:    return DOWN ? 2'd2 : 2'd3;
      2'd2:    return 2'd1;
      default: return DOWN ? 2'd3 : 2'd2;
    endcase
  endfunction

  function automatic logic [1:0] qsel(input logic [1:0] p);
    case (p)
      2'd0:    return 2'd2;
      2'd1:    return DOWN ? 2'd1 : 2'd0;
      2'd2:    return 2'd3;
      default: return DOWN ? 2'd0 : 2'd1;
    endcase
  endfunction

  logic [1:0]          ph;
  logic signed [W-1:0] tap [4];

  always_comb begin
    tap[0] = in_i;
    tap[1] = sneg(in_i);
    tap[2] = in_q;
    tap[3] = sneg(in_q);
  end

  assign phase_en = 4'b0001 << ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= 2'd0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ph    <= ph + 2'd1;
        out_i <= tap[isel(ph)];
        out_q <= tap[qsel(ph)];
      end
    end
  end
endmodule

// File: rtl/qrot_mixer_sva.sv
module qrot_mixer_sva #(
  parameter int W    = 12,
  parameter bit DOWN = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic signed [W-1:0] in_i,
  input logic signed [W-1:0] in_q,
  input logic                out_valid,
  input logic signed [W-1:0] out_i,
  input logic signed [W-1:0] out_q,
  input logic [3:0]          phase_en
);
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_en) == 1);

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> phase_en == {$past(phase_en[2:0]), $past(phase_en[3])});

  p_hold_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase_en));

  p_valid_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_i) && $stable(out_q)));

  p_phase0_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phase_en[0]) |=> (out_i == $past(in_i) && out_q == $past(in_q)));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phase_en[2]) |=> (out_i != SMIN && out_q != SMIN));
endmodule

bind qrot_mixer qrot_mixer_sva #(.W(W), .DOWN(DOWN)) sva_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .phase_en(phase_en)
);

// File: tb/qrot_mixer_tb_top.sv
`timescale 1ns/1ps
module qrot_mixer_tb_top;
  localparam int W = 12;
  localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic clk = 1'b0, rst_n = 1'b1, in_valid = 1'b0;
  logic signed [W-1:0] in_i = '0, in_q = '0;
  logic dn_valid, up_valid;
  logic signed [W-1:0] dn_i, dn_q, up_i, up_q;
  logic [3:0] dn_ph, up_ph;

  always #2.5 clk = ~clk;

  qrot_mixer #(.W(W), .DOWN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(dn_valid), .out_i(dn_i), .out_q(dn_q), .phase_en(dn_ph));

  qrot_mixer #(.W(W), .DOWN(1'b0)) dut_up_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(up_valid), .out_i(up_i), .out_q(up_q), .phase_en(up_ph));

  typedef struct packed {
    logic v;
    logic signed [W-1:0] di, dq, ui, uq;
  } exp_t;

  exp_t  q_exp[$];
  string q_tag[$];
  int checks = 0, fails = 0, ph = 0;
  logic signed [W-1:0] hdi = '0, hdq = '0, hui = '0, huq = '0;

  function automatic logic signed [W-1:0] sneg(input logic signed [W-1:0] x);
    if (x == SMIN) return SMAX;
    return -x;
  endfunction

  task automatic mix(input bit dn, input int p, input logic signed [W-1:0] a, b,
                     output logic signed [W-1:0] oi, oq);
    case (p)
      0: begin oi = a; oq = b; end
      1: if (dn) begin oi = b; oq = sneg(a); end else begin oi = sneg(b); oq = a; end
      2: begin oi = sneg(a); oq = sneg(b); end
      default: if (dn) begin oi = sneg(b); oq = a; end else begin oi = b; oq = sneg(a); end
    endcase
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic signed [W-1:0] a, b, input string tag);
    logic signed [W-1:0] t1, t2;
    @(negedge clk);
    check("R5/R6", "phase_en down", int'(dn_ph), 1 << ph);
    check("R5/R6", "phase_en up", int'(up_ph), 1 << ph);
    in_valid = v; in_i = a; in_q = b;
    if (v) begin
      mix(1'b1, ph, a, b, t1, t2); hdi = t1; hdq = t2;
      mix(1'b0, ph, a, b, t1, t2); hui = t1; huq = t2;
      ph = (ph + 1) % 4;
    end
    q_exp.push_back({v, hdi, hdq, hui, huq});
    q_tag.push_back(tag);
  endtask

  initial begin : monitor
    exp_t  e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check({t, "/R7"}, "out_valid down", int'(dn_valid), int'(e.v));
        check({t, "/R7"}, "out_valid up", int'(up_valid), int'(e.v));
        check(t, "out_i down", int'(dn_i), int'(e.di));
        check(t, "out_q down", int'(dn_q), int'(e.dq));
        check(t, "out_i up", int'(up_i), int'(e.ui));
        check(t, "out_q up", int'(up_q), int'(e.uq));
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5.0);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check_reset_state;
    check("R1", "phase_en", int'(dn_ph), 1);
    check("R1", "out_valid", int'(dn_valid), 0);
    check("R1", "out_i", int'(dn_i), 0);
    check("R1", "out_q", int'(dn_q), 0);
    check("R1", "phase_en up", int'(up_ph), 1);
  endtask

  initial begin : stim
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    // constant input: four-step rotation in both directions
    for (int k = 0; k < 8; k++) drive(1'b1, 12'sd100, -12'sd37, "R2/R3");
    // ramp: distinct value per phase
    for (int k = 0; k < 8; k++)
      drive(1'b1, W'(k * 37 - 120), W'(200 - k * 53), "R2/R3");
    // valid gaps: phase and data hold
    for (int k = 0; k < 12; k++)
      drive((k % 3) == 0, W'(k * 11), W'(-k * 7), "R5/R8");
    // full-scale inputs through every phase
    for (int k = 0; k < 4; k++) drive(1'b1, SMIN, SMIN, "R4");
    for (int k = 0; k < 4; k++) drive(1'b1, SMAX, SMIN, "R4");
    for (int k = 0; k < 4; k++) drive(1'b1, SMIN, SMAX, "R4");
    drive(1'b0, '0, '0, "R8");
    drive(1'b0, '0, '0, "R8");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule